// File: doc/BRIEF.md
# Outstanding-Transaction Issue Limiter

This block sits between a request source (cache refill, write buffer or similar) and an AXI manager port. It accepts read and write address requests and forwards them to one-deep AR and AW register stages. Each request is counted against a read budget, a write budget and a combined budget. The count is taken at acceptance, so an address phase that has been offered stays valid until the subordinate takes it. Completions free budget: a read frees its slot on the R beat marked last, and a write frees its slot on the B handshake.

A profile parameter picks one of three budget sets. Responses are assumed to arrive strictly in issue order, with no reordering and no write-data interleaving. For that reason the block drives a single fixed ID on AR, and one fixed ID on both AW and W. The W data path itself, the caches and interconnect arbitration lie outside the block.

Top module: `axi_issue_limiter`

## Requirements
- R1: Limits by PROFILE (read/write/combined): PROF_RW = 2/2/4, PROF_RO = 2/0/2, PROF_SINGLE = 1/1/1. rd_cnt_o and wr_cnt_o never exceed them, and a request arriving at a direction's limit is refused unless a completion happens in the same cycle.
- R2: rd_req_ready_o is high when the AR stage is empty or being taken (ar_ready_i), the read count is below its limit or a read completes this cycle, and the combined count net of this cycle's completions is below the combined limit.
- R3: wr_req_ready_o follows the same rule for the write side. When both directions would fit only one more transaction in the combined budget, an accepted read wins and the write waits.
- R4: A read slot is released only by a cycle with r_valid_i, r_ready_i and r_last_i all high. Beats without r_last_i, or without the handshake, leave rd_cnt_o unchanged.
- R5: A write slot is released by a cycle with b_valid_i and b_ready_i both high. b_valid_i without b_ready_i has no effect.
- R6: If an acceptance and a release of the same direction fall in the same cycle, the count holds its value. Otherwise it moves by one, in the cycle after the event.
- R7: An accepted request appears on ar_*/aw_* one cycle later with the same address and length. It stays valid and stable until the matching ready is high.
- R8: ar_id_o always equals RD_ID. aw_id_o and w_id_o always equal WR_ID, so the two are identical.
- R9: Under PROF_RO, wr_req_ready_o and aw_valid_o are always low and wr_cnt_o stays 0.
- R10: While rst_ni is low, both counts are 0, both address valids are low, and ar_valid_o and aw_valid_o first rise only after an accepted request.
- R11: A completion arriving while its direction's count is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_valid_i | input | 1 | Read request offered |
| rd_req_addr_i | input | ADDR_W | Read request address |
| rd_req_len_i | input | LEN_W | Read burst length |
| rd_req_ready_o | output | 1 | Read request accepted |
| wr_req_valid_i | input | 1 | Write request offered |
| wr_req_addr_i | input | ADDR_W | Write request address |
| wr_req_len_i | input | LEN_W | Write burst length |
| wr_req_ready_o | output | 1 | Write request accepted |
| ar_valid_o | output | 1 | Read address valid |
| ar_addr_o | output | ADDR_W | Read address |
| ar_len_o | output | LEN_W | Read burst length |
| ar_id_o | output | ID_W | Fixed read ID |
| ar_ready_i | input | 1 | Read address ready |
| aw_valid_o | output | 1 | Write address valid |
| aw_addr_o | output | ADDR_W | Write address |
| aw_len_o | output | LEN_W | Write burst length |
| aw_id_o | output | ID_W | Fixed write ID |
| aw_ready_i | input | 1 | Write address ready |
| w_id_o | output | ID_W | Write data ID, equal to aw_id_o |
| r_valid_i | input | 1 | Read data valid (observed) |
| r_ready_i | input | 1 | Read data ready (observed) |
| r_last_i | input | 1 | Last read beat |
| b_valid_i | input | 1 | Write response valid (observed) |
| b_ready_i | input | 1 | Write response ready (observed) |
| rd_cnt_o | output | 3 | Reads reserved or outstanding |
| wr_cnt_o | output | 3 | Writes reserved or outstanding |

## Verification
The properties place no constraint on the ready and response inputs. They assume only that each qualifying R or B handshake stands for one completion, and they exclude stray completions at a count of zero when predicting releases. The stimulus drives every ready and response line independently at random, including stray completions and non-last beats. It runs the same sequence into all three profiles at once, so each profile's limits, contention and same-cycle cases are exercised under identical traffic.

// File: rtl/axi_lim_pkg.sv
package axi_lim_pkg;
  typedef enum logic [1:0] {
    PROF_RO     = 2'd0,
    PROF_RW     = 2'd1,
    PROF_SINGLE = 2'd2
  } port_profile_e;

  localparam int unsigned CNT_W = 3;

  function automatic int unsigned rd_limit(port_profile_e p);
    case (p)
      PROF_SINGLE: return 1;
      default:     return 2;
    endcase
  endfunction

  function automatic int unsigned wr_limit(port_profile_e p);
    case (p)
      PROF_RO:     return 0;
      PROF_SINGLE: return 1;
      default:     return 2;
    endcase
  endfunction

  function automatic int unsigned tot_limit(port_profile_e p);
    case (p)
      PROF_RO:     return 2;
      PROF_SINGLE: return 1;
      default:     return 4;
    endcase
  endfunction
endpackage

// File: rtl/lim_addr_stage.sv
module lim_addr_stage #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          free_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;

  assign free_o  = ~valid_q | ready_i;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;

  // load_i is only raised when free_o is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      len_q   <= len_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lim_slot_counter.sv
module lim_slot_counter #(
  parameter int unsigned MAX = 2,
  parameter int unsigned W   = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         fin_i,
  output logic [W-1:0] cnt_o,
  output logic         room_o,
  output logic         rel_o
);
  localparam logic [W-1:0] MAX_C = W'(MAX);

  logic [W-1:0] cnt_q;

  // completions with nothing outstanding are dropped
  assign rel_o  = fin_i & (cnt_q != '0);
  assign room_o = (cnt_q < MAX_C) | rel_o;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (inc_i & ~rel_o) cnt_q <= cnt_q + 1'b1;
    else if (~inc_i & rel_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lim_budget.sv
module lim_budget #(
  parameter int unsigned TOT_MAX = 4,
  parameter int unsigned W       = 3
) (
  input  logic [W-1:0] rd_cnt_i,
  input  logic [W-1:0] wr_cnt_i,
  input  logic         rd_rel_i,
  input  logic         wr_rel_i,
  input  logic         rd_room_i,
  input  logic         wr_room_i,
  input  logic         ar_free_i,
  input  logic         aw_free_i,
  input  logic         rd_valid_i,
  input  logic         wr_valid_i,
  output logic         rd_ready_o,
  output logic         wr_ready_o
);
  localparam int unsigned SW = W + 2;
  localparam logic [SW-1:0] TOT_C = SW'(TOT_MAX);

  logic [SW-1:0] used;
  logic [SW-1:0] used_wr;
  logic          rd_take;

  always_comb begin
    used       = SW'(rd_cnt_i) + SW'(wr_cnt_i) - SW'(rd_rel_i) - SW'(wr_rel_i);
    rd_ready_o = ar_free_i & rd_room_i & (used < TOT_C);
    rd_take    = rd_ready_o & rd_valid_i;
    // a read taken this cycle claims combined room first
    used_wr    = used + SW'(rd_take);
    wr_ready_o = aw_free_i & wr_room_i & (used_wr < TOT_C);
  end
endmodule

// File: rtl/axi_issue_limiter.sv
module axi_issue_limiter
  import axi_lim_pkg::*;
#(
  parameter port_profile_e    PROFILE = PROF_RW,
  parameter int unsigned      ADDR_W  = 32,
  parameter int unsigned      LEN_W   = 8,
  parameter int unsigned      ID_W    = 4,
  parameter logic [ID_W-1:0]  RD_ID   = ID_W'(3),
  parameter logic [ID_W-1:0]  WR_ID   = ID_W'(5)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_valid_i,
  input  logic [ADDR_W-1:0]   rd_req_addr_i,
  input  logic [LEN_W-1:0]    rd_req_len_i,
  output logic                rd_req_ready_o,
  input  logic                wr_req_valid_i,
  input  logic [ADDR_W-1:0]   wr_req_addr_i,
  input  logic [LEN_W-1:0]    wr_req_len_i,
  output logic                wr_req_ready_o,
  output logic                ar_valid_o,
  output logic [ADDR_W-1:0]   ar_addr_o,
  output logic [LEN_W-1:0]    ar_len_o,
  output logic [ID_W-1:0]     ar_id_o,
  input  logic                ar_ready_i,
  output logic                aw_valid_o,
  output logic [ADDR_W-1:0]   aw_addr_o,
  output logic [LEN_W-1:0]    aw_len_o,
  output logic [ID_W-1:0]     aw_id_o,
  input  logic                aw_ready_i,
  output logic [ID_W-1:0]     w_id_o,
  input  logic                r_valid_i,
  input  logic                r_ready_i,
  input  logic                r_last_i,
  input  logic                b_valid_i,
  input  logic                b_ready_i,
  output logic [CNT_W-1:0]    rd_cnt_o,
  output logic [CNT_W-1:0]    wr_cnt_o
);
  localparam int unsigned RD_MAX  = rd_limit(PROFILE);
  localparam int unsigned WR_MAX  = wr_limit(PROFILE);
  localparam int unsigned TOT_MAX = tot_limit(PROFILE);
  localparam int unsigned CW      = CNT_W;

  logic rd_fin, wr_fin;
  logic rd_take, wr_take;
  logic ar_free, aw_free;
  logic rd_room, wr_room;
  logic rd_rel, wr_rel;

  assign rd_fin  = r_valid_i & r_ready_i & r_last_i;
  assign wr_fin  = b_valid_i & b_ready_i;
  assign rd_take = rd_req_valid_i & rd_req_ready_o;
  assign wr_take = wr_req_valid_i & wr_req_ready_o;

  // fixed IDs: no reordering, AW and W share one value
  assign ar_id_o = RD_ID;
  assign aw_id_o = WR_ID;
  assign w_id_o  = WR_ID;

  lim_addr_stage #(.AW(ADDR_W), .LW(LEN_W)) u_ar_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_take),
    .addr_i  (rd_req_addr_i),
    .len_i   (rd_req_len_i),
    .ready_i (ar_ready_i),
    .valid_o (ar_valid_o),
    .addr_o  (ar_addr_o),
    .len_o   (ar_len_o),
    .free_o  (ar_free)
  );

  lim_slot_counter #(.MAX(RD_MAX), .W(CW)) u_rd_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rd_take),
    .fin_i  (rd_fin),
    .cnt_o  (rd_cnt_o),
    .room_o (rd_room),
    .rel_o  (rd_rel)
  );

  if (WR_MAX == 0) begin : g_no_wr
    logic unused_wr;
    assign unused_wr  = ^{wr_req_addr_i, wr_req_len_i, aw_ready_i, wr_take, wr_fin};
    assign aw_free    = 1'b0;
    assign wr_room    = 1'b0;
    assign wr_rel     = 1'b0;
    assign wr_cnt_o   = '0;
    assign aw_valid_o = 1'b0;
    assign aw_addr_o  = '0;
    assign aw_len_o   = '0;
  end else begin : g_wr
    lim_addr_stage #(.AW(ADDR_W), .LW(LEN_W)) u_aw_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (wr_take),
      .addr_i  (wr_req_addr_i),
      .len_i   (wr_req_len_i),
      .ready_i (aw_ready_i),
      .valid_o (aw_valid_o),
      .addr_o  (aw_addr_o),
      .len_o   (aw_len_o),
      .free_o  (aw_free)
    );

    lim_slot_counter #(.MAX(WR_MAX), .W(CW)) u_wr_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (wr_take),
      .fin_i  (wr_fin),
      .cnt_o  (wr_cnt_o),
      .room_o (wr_room),
      .rel_o  (wr_rel)
    );
  end

  lim_budget #(.TOT_MAX(TOT_MAX), .W(CW)) u_budget (
    .rd_cnt_i   (rd_cnt_o),
    .wr_cnt_i   (wr_cnt_o),
    .rd_rel_i   (rd_rel),
    .wr_rel_i   (wr_rel),
    .rd_room_i  (rd_room),
    .wr_room_i  (wr_room),
    .ar_free_i  (ar_free),
    .aw_free_i  (aw_free),
    .rd_valid_i (rd_req_valid_i),
    .wr_valid_i (wr_req_valid_i),
    .rd_ready_o (rd_req_ready_o),
    .wr_ready_o (wr_req_ready_o)
  );
endmodule

// File: rtl/axi_issue_limiter_chk.sv
module axi_issue_limiter_chk
  import axi_lim_pkg::*;
#(
  parameter port_profile_e PROFILE = PROF_RW,
  parameter int unsigned   ADDR_W  = 32,
  parameter int unsigned   LEN_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_valid_i,
  input logic [ADDR_W-1:0] rd_req_addr_i,
  input logic              rd_req_ready_o,
  input logic              wr_req_valid_i,
  input logic [ADDR_W-1:0] wr_req_addr_i,
  input logic              wr_req_ready_o,
  input logic              ar_valid_o,
  input logic [ADDR_W-1:0] ar_addr_o,
  input logic [LEN_W-1:0]  ar_len_o,
  input logic              ar_ready_i,
  input logic              aw_valid_o,
  input logic [ADDR_W-1:0] aw_addr_o,
  input logic [LEN_W-1:0]  aw_len_o,
  input logic              aw_ready_i,
  input logic              r_valid_i,
  input logic              r_ready_i,
  input logic              r_last_i,
  input logic              b_valid_i,
  input logic              b_ready_i,
  input logic [CNT_W-1:0]  rd_cnt_o,
  input logic [CNT_W-1:0]  wr_cnt_o
);
  localparam logic [CNT_W-1:0] RD_C  = CNT_W'(rd_limit(PROFILE));
  localparam logic [CNT_W-1:0] WR_C  = CNT_W'(wr_limit(PROFILE));
  localparam logic [CNT_W:0]   TOT_C = (CNT_W+1)'(tot_limit(PROFILE));

  logic rd_acc, wr_acc, rd_fin, wr_fin;
  assign rd_acc = rd_req_valid_i & rd_req_ready_o;
  assign wr_acc = wr_req_valid_i & wr_req_ready_o;
  assign rd_fin = r_valid_i & r_ready_i & r_last_i & (rd_cnt_o != '0);
  assign wr_fin = b_valid_i & b_ready_i & (wr_cnt_o != '0);

  a_r1_rd_cap: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_cnt_o <= RD_C);
  a_r1_wr_cap: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_cnt_o <= WR_C);
  a_r3_tot_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, rd_cnt_o} + {1'b0, wr_cnt_o}) <= TOT_C);
  a_r7_ar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o) && $stable(ar_len_o));
  a_r7_aw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o && !aw_ready_i |=> aw_valid_o && $stable(aw_addr_o) && $stable(aw_len_o));
  a_r7_ar_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> ar_valid_o && ar_addr_o == $past(rd_req_addr_i));
  a_r7_aw_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> aw_valid_o && aw_addr_o == $past(wr_req_addr_i));
  a_r4_rd_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fin && !rd_acc |=> rd_cnt_o == $past(rd_cnt_o) - 3'd1);
  a_r5_wr_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fin && !wr_acc |=> wr_cnt_o == $past(wr_cnt_o) - 3'd1);
  a_r6_rd_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc && rd_fin |=> $stable(rd_cnt_o));
  a_r6_wr_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && wr_fin |=> $stable(wr_cnt_o));
endmodule

bind axi_issue_limiter axi_issue_limiter_chk #(
  .PROFILE(PROFILE), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/axi_issue_limiter_bench.sv
`timescale 1ns/1ps
module axi_issue_limiter_bench;
  import axi_lim_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rd_v, wr_v, arr, awr, rvld, rrdy_in, rlast, bv, br;
  logic [31:0] rd_a, wr_a;
  logic [7:0]  rd_l, wr_l;

  // index 0: read/write, 1: read-only, 2: single
  logic        rrdy[3], wrdy[3], arv[3], awv[3];
  logic [31:0] ara[3], awa[3];
  logic [7:0]  arl[3], awl[3];
  logic [2:0]  rc[3], wc[3];
  logic [3:0]  arid[3], awid[3], wid[3];

  axi_issue_limiter #(.PROFILE(PROF_RW)) u_axi_issue_limiter (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_valid_i(rd_v), .rd_req_addr_i(rd_a), .rd_req_len_i(rd_l), .rd_req_ready_o(rrdy[0]),
    .wr_req_valid_i(wr_v), .wr_req_addr_i(wr_a), .wr_req_len_i(wr_l), .wr_req_ready_o(wrdy[0]),
    .ar_valid_o(arv[0]), .ar_addr_o(ara[0]), .ar_len_o(arl[0]), .ar_id_o(arid[0]), .ar_ready_i(arr),
    .aw_valid_o(awv[0]), .aw_addr_o(awa[0]), .aw_len_o(awl[0]), .aw_id_o(awid[0]), .aw_ready_i(awr),
    .w_id_o(wid[0]), .r_valid_i(rvld), .r_ready_i(rrdy_in), .r_last_i(rlast),
    .b_valid_i(bv), .b_ready_i(br), .rd_cnt_o(rc[0]), .wr_cnt_o(wc[0]));

  axi_issue_limiter #(.PROFILE(PROF_RO)) u_ro (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_valid_i(rd_v), .rd_req_addr_i(rd_a), .rd_req_len_i(rd_l), .rd_req_ready_o(rrdy[1]),
    .wr_req_valid_i(wr_v), .wr_req_addr_i(wr_a), .wr_req_len_i(wr_l), .wr_req_ready_o(wrdy[1]),
    .ar_valid_o(arv[1]), .ar_addr_o(ara[1]), .ar_len_o(arl[1]), .ar_id_o(arid[1]), .ar_ready_i(arr),
    .aw_valid_o(awv[1]), .aw_addr_o(awa[1]), .aw_len_o(awl[1]), .aw_id_o(awid[1]), .aw_ready_i(awr),
    .w_id_o(wid[1]), .r_valid_i(rvld), .r_ready_i(rrdy_in), .r_last_i(rlast),
    .b_valid_i(bv), .b_ready_i(br), .rd_cnt_o(rc[1]), .wr_cnt_o(wc[1]));

  axi_issue_limiter #(.PROFILE(PROF_SINGLE)) u_single (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_valid_i(rd_v), .rd_req_addr_i(rd_a), .rd_req_len_i(rd_l), .rd_req_ready_o(rrdy[2]),
    .wr_req_valid_i(wr_v), .wr_req_addr_i(wr_a), .wr_req_len_i(wr_l), .wr_req_ready_o(wrdy[2]),
    .ar_valid_o(arv[2]), .ar_addr_o(ara[2]), .ar_len_o(arl[2]), .ar_id_o(arid[2]), .ar_ready_i(arr),
    .aw_valid_o(awv[2]), .aw_addr_o(awa[2]), .aw_len_o(awl[2]), .aw_id_o(awid[2]), .aw_ready_i(awr),
    .w_id_o(wid[2]), .r_valid_i(rvld), .r_ready_i(rrdy_in), .r_last_i(rlast),
    .b_valid_i(bv), .b_ready_i(br), .rd_cnt_o(rc[2]), .wr_cnt_o(wc[2]));

  int n_chk = 0;
  int n_err = 0;

  int          m_rc[3], m_wc[3];
  bit          m_arv[3], m_awv[3];
  logic [31:0] m_ara[3], m_awa[3];
  logic [7:0]  m_arl[3], m_awl[3];
  logic        last_rrdy[3], last_wrdy[3];

  function automatic int rmax(int i); return (i == 2) ? 1 : 2; endfunction
  function automatic int wmax(int i); return (i == 0) ? 2 : ((i == 1) ? 0 : 1); endfunction
  function automatic int tmax(int i); return (i == 0) ? 4 : ((i == 1) ? 2 : 1); endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit a_rv, logic [31:0] a_ra, logic [7:0] a_rl,
                      bit a_wv, logic [31:0] a_wa, logic [7:0] a_wl,
                      bit a_arr, bit a_awr, bit a_rvld, bit a_rrdy, bit a_rlast,
                      bit a_bv, bit a_br);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R7 ar_valid", arv[i], m_arv[i]);
      if (m_arv[i]) begin
        chk("R7 ar_addr", ara[i], m_ara[i]);
        chk("R7 ar_len", arl[i], m_arl[i]);
      end
      chk((i == 1) ? "R9 aw_valid" : "R7 aw_valid", awv[i], m_awv[i]);
      if (m_awv[i]) begin
        chk("R7 aw_addr", awa[i], m_awa[i]);
        chk("R7 aw_len", awl[i], m_awl[i]);
      end
      chk("R6 rd_cnt", rc[i], m_rc[i]);
      chk((i == 1) ? "R9 wr_cnt" : "R6 wr_cnt", wc[i], m_wc[i]);
    end
    rd_v = a_rv; rd_a = a_ra; rd_l = a_rl;
    wr_v = a_wv; wr_a = a_wa; wr_l = a_wl;
    arr = a_arr; awr = a_awr;
    rvld = a_rvld; rrdy_in = a_rrdy; rlast = a_rlast;
    bv = a_bv; br = a_br;
    #1;
    for (int i = 0; i < 3; i++) begin
      bit rdone, wdone, er, ew, rtake, wtake;
      int used;
      rdone = a_rvld && a_rrdy && a_rlast && (m_rc[i] != 0);
      wdone = a_bv && a_br && (m_wc[i] != 0);
      used  = m_rc[i] + m_wc[i] - int'(rdone) - int'(wdone);
      er = (!m_arv[i] || a_arr) && (m_rc[i] < rmax(i) || rdone) && (used < tmax(i));
      rtake = er && a_rv;
      ew = (wmax(i) != 0) && (!m_awv[i] || a_awr) && (m_wc[i] < wmax(i) || wdone)
           && (used + int'(rtake) < tmax(i));
      wtake = ew && a_wv;
      chk("R2 rd_ready", rrdy[i], er);
      chk((i == 1) ? "R9 wr_ready" : "R3 wr_ready", wrdy[i], ew);
      last_rrdy[i] = rrdy[i];
      last_wrdy[i] = wrdy[i];
      if (rtake) begin m_arv[i] = 1; m_ara[i] = a_ra; m_arl[i] = a_rl; end
      else if (a_arr) m_arv[i] = 0;
      if (wtake) begin m_awv[i] = 1; m_awa[i] = a_wa; m_awl[i] = a_wl; end
      else if (a_awr) m_awv[i] = 0;
      m_rc[i] = m_rc[i] + int'(rtake) - int'(rdone);
      m_wc[i] = m_wc[i] + int'(wtake) - int'(wdone);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rd_v = 0; wr_v = 0; arr = 0; awr = 0; rvld = 0; rrdy_in = 0; rlast = 0; bv = 0; br = 0;
    rd_a = 0; wr_a = 0; rd_l = 0; wr_l = 0;
    for (int i = 0; i < 3; i++) begin
      m_rc[i] = 0; m_wc[i] = 0; m_arv[i] = 0; m_awv[i] = 0;
      m_ara[i] = 0; m_awa[i] = 0; m_arl[i] = 0; m_awl[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    for (int i = 0; i < 3; i++) begin
      chk("R10 rd_cnt", rc[i], 0);
      chk("R10 wr_cnt", wc[i], 0);
      chk("R10 ar_valid", arv[i], 0);
      chk("R10 aw_valid", awv[i], 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fill reads to each profile's limit
    step(1, 32'h100, 8'd3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 32'h200, 8'd7, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R1 single rd refused at limit", last_rrdy[2], 0);
    step(1, 32'h300, 8'd1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R1 rw rd refused at limit", last_rrdy[0], 0);
    // R6: accept at limit with same-cycle completion, count holds
    step(1, 32'h400, 8'd2, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0);
    chk("R6 accept at limit", last_rrdy[0], 1);
    after_edge();
    chk("R6 rw count held", rc[0], 2);
    chk("R6 single count held", rc[2], 1);
    // R4: non-last beat and unhandshaken last beat release nothing
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0);
    after_edge();
    chk("R4 non-last beat", rc[0], 2);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0);
    after_edge();
    chk("R4 no handshake", rc[0], 2);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0);
    after_edge();
    chk("R4 last beat releases", rc[0], 1);
    // R11: write completion with no write outstanding
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    after_edge();
    chk("R11 stray b rw", wc[0], 0);
    chk("R11 stray b single", wc[2], 0);
    drain();
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0);
    after_edge();
    chk("R11 stray r", rc[0], 0);

    // writes
    step(0, 0, 0, 1, 32'hA00, 8'd4, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 ro write refused", last_wrdy[1], 0);
    step(0, 0, 0, 1, 32'hB00, 8'd5, 1, 1, 0, 0, 0, 0, 0);
    chk("R1 single wr refused at limit", last_wrdy[2], 0);
    after_edge();
    chk("R1 rw two writes", wc[0], 2);
    // R5: b without ready, then with ready
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 0);
    after_edge();
    chk("R5 b without ready", wc[0], 2);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    after_edge();
    chk("R5 b releases", wc[0], 1);
    drain();
    // R3: contention for the last combined slot
    step(1, 32'hC00, 8'd0, 1, 32'hD00, 8'd0, 1, 1, 0, 0, 0, 0, 0);
    chk("R3 single read wins", last_rrdy[2], 1);
    chk("R3 single write waits", last_wrdy[2], 0);
    chk("R3 rw both accepted", last_wrdy[0], 1);
    drain();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 3) != 0, $urandom, 8'($urandom),
           ($urandom % 3) != 0, $urandom, 8'($urandom),
           ($urandom % 4) != 0, ($urandom % 4) != 0,
           ($urandom % 2) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
           ($urandom % 2) != 0, ($urandom % 4) != 0);
    end
    drain();

    // R8: fixed IDs
    for (int i = 0; i < 3; i++) begin
      chk("R8 ar_id", arid[i], 3);
      chk("R8 aw_id", awid[i], 5);
      chk("R8 w_id equals aw_id", wid[i], awid[i]);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule